// File: doc/BRIEF.md
# UART Host Register File

This block is the register file that a host processor sees in a 16550-style serial port. It takes a 3-bit offset, a byte of write data and single-cycle read and write strobes. From these it serves the receive and transmit byte paths, the baud divisor, the line and modem control bytes, the FIFO control byte, the line and modem status bytes and a scratch byte. Bit 7 of the line-control byte switches the two lowest offsets between the data path and the divisor halves. The serial shifter and the FIFOs sit outside this block. They report to it through level and pulse inputs, and they take their control from its outputs.

The block also merges four interrupt sources into one identification code with a fixed priority. It drives a single interrupt line, which passes only while bit 3 of the modem-control byte is set. Read data is combinational from the offset. Read and write side effects take place at the clock edge that ends the strobe cycle.

The byte handed to the transmitter leaves as a one-cycle `tx_valid` pulse with no back-pressure. The host must see the holding-empty status before it writes. The receive side works the same way: `rx_pop` pulses once per read of the receive offset, and the receiver must present its next byte on `rx_data` by the following read.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the line-control, modem-control, interrupt-enable, scratch and divisor registers are all zero, the identification byte reads 0x01 and `irq` is low.
- R2: With line-control bit 7 at 0, a read of offset 0 returns `rx_data` and pulses `rx_pop` in that cycle. A write to offset 0 pulses `tx_valid`, with `tx_data` equal to the written byte.
- R3: With line-control bit 7 at 1, offsets 0 and 1 read and write the low and high bytes of `divisor`. These accesses raise neither `rx_pop` nor `tx_valid` and leave the interrupt-enable register unchanged. The divisor changes only on a write.
- R4: With line-control bit 7 at 0, offset 1 is the interrupt-enable register. Bit 0 enables received data, bit 1 holding empty, bit 2 line status and bit 3 modem status. Bits 7:4 read as 0.
- R5: Offset 2 reads the identification byte and, on a write, pulses `fifo_wr` with `fifo_ctrl` equal to the written byte, whatever bit 7 of line control is. Written bit 0 is kept as `fifo_en`, and it is copied into identification bits 7:6.
- R6: Offset 3 (line control, 8 bits), offset 4 (modem control, bits 4:0, bits 7:5 read 0) and offset 7 (scratch) read back what was written, whatever bit 7 of line control is.
- R7: Offset 5 reads {0, thr_empty, thr_empty, err[3:0], rx_avail}. A `line_err` pulse bit sets err bit n until the next read of offset 5, which clears it. Writes to offsets 5 and 6 have no effect.
- R8: Offset 6 reads {lines[3:0], delta[3:0]}. Lines is `modem_in` registered once. A delta bit sets when its input differs from the registered copy, and it clears on a read of offset 6.
- R9: The identification byte has bits 3:0 of 0x6 for line status (pending when enabled and any err bit is set), 0x4 for received data, 0x2 for holding empty and 0x0 for modem status (enabled and any delta bit set). Bits 3:0 are 0x1 when nothing is pending, and the highest-priority source is reported in that order.
- R10: The holding-empty source is pending while it is enabled, its flag is set and `thr_empty` is high. The flag sets on a rising edge of `thr_empty` (the registered copy resets low), or when an interrupt-enable write turns bit 1 on while `thr_empty` is high. It clears on a write to offset 0 or on a read of offset 2 that reports code 0x2, and a clear wins over a set.
- R11: `irq` is high exactly when some source is pending and modem-control bit 3 is 1. While that bit is 0, `irq` stays low and the identification byte still reports the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data for `addr` (combinational) |
| rx_data | input | 8 | Byte at the head of the receiver |
| rx_avail | input | 1 | Receiver holds at least one byte |
| rx_pop | output | 1 | Receive byte taken by the host |
| tx_data | output | 8 | Byte for the transmitter |
| tx_valid | output | 1 | `tx_data` is valid in this cycle |
| thr_empty | input | 1 | Transmit holding space is empty |
| line_err | input | 4 | Error event pulses: overrun, parity, framing, break |
| modem_in | input | 4 | Modem input lines |
| lcr | output | 8 | Line-control byte |
| mcr | output | 5 | Modem-control bits |
| fifo_ctrl | output | 8 | FIFO control byte being written |
| fifo_wr | output | 1 | FIFO control write strobe |
| fifo_en | output | 1 | FIFOs enabled |
| divisor | output | 16 | Baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default byte width of 8, so the divisor is 16 bits and the three offset bits cover all ten register targets. At that width every offset can be reached under both settings of the access bit. Each interrupt source can then be raised on its own and in combination, which shows every identification code, the order of priority and the clearing side effects, with the gate bit both off and on.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  parameter int BYTE_W = 8;
  parameter int ADDR_W = 3;
  localparam int DIV_W = 2 * BYTE_W;
  localparam int N_SRC = 4;
  localparam int ID_W  = 4;

  localparam logic [ID_W-1:0] ID_NONE = 4'h1;
  localparam logic [ID_W-1:0] ID_LINE = 4'h6;
  localparam logic [ID_W-1:0] ID_RXD  = 4'h4;
  localparam logic [ID_W-1:0] ID_THRE = 4'h2;
  localparam logic [ID_W-1:0] ID_MDM  = 4'h0;

  typedef struct packed {
    logic data;
    logic div_lo;
    logic div_hi;
    logic ien;
    logic ident;
    logic lctl;
    logic mctl;
    logic lstat;
    logic mstat;
    logic scratch;
  } target_t;
endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dlab,
  output target_t           tgt
);
  always_comb begin
    tgt = '0;
    case (addr)
      3'd0:    if (dlab) tgt.div_lo = 1'b1; else tgt.data = 1'b1;
      3'd1:    if (dlab) tgt.div_hi = 1'b1; else tgt.ien  = 1'b1;
      3'd2:    tgt.ident   = 1'b1;
      3'd3:    tgt.lctl    = 1'b1;
      3'd4:    tgt.mctl    = 1'b1;
      3'd5:    tgt.lstat   = 1'b1;
      3'd6:    tgt.mstat   = 1'b1;
      default: tgt.scratch = 1'b1;
    endcase
  end

  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt) && (tgt.div_lo || tgt.div_hi) |-> dlab);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_reg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_SRC-1:0] ien,
  input  logic            line_cond,
  input  logic            rxd_cond,
  input  logic            thre_cond,
  input  logic            mdm_cond,
  input  logic            gate,
  output logic [ID_W-1:0] id,
  output logic            irq
);
  logic [N_SRC-1:0] pend;

  always_comb begin
    pend = {ien[3] & mdm_cond, ien[1] & thre_cond, ien[0] & rxd_cond, ien[2] & line_cond};
    if      (pend[0]) id = ID_LINE;
    else if (pend[1]) id = ID_RXD;
    else if (pend[2]) id = ID_THRE;
    else if (pend[3]) id = ID_MDM;
    else              id = ID_NONE;
    irq = gate & (|pend);
  end

  a_r11_gate_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> !irq);
  a_r9_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[2] && line_cond) |-> id == ID_LINE);
  a_r9_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (id == ID_NONE) |-> !irq);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_avail,
  output logic              rx_pop,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              thr_empty,
  input  logic [N_SRC-1:0]  line_err,
  input  logic [N_SRC-1:0]  modem_in,
  output logic [BYTE_W-1:0] lcr,
  output logic [4:0]        mcr,
  output logic [BYTE_W-1:0] fifo_ctrl,
  output logic              fifo_wr,
  output logic              fifo_en,
  output logic [DIV_W-1:0]  divisor,
  output logic              irq
);
  localparam int DLAB_BIT = BYTE_W - 1;
  localparam int OUT2_BIT = 3;

  target_t          tgt;
  logic [N_SRC-1:0] ien_q, err_q, line_q, delta_q;
  logic [BYTE_W-1:0] lcr_q, scr_q, div_lo_q, div_hi_q;
  logic [4:0]       mcr_q;
  logic             fen_q, thr_q, thre_flag;
  logic [ID_W-1:0]  id;
  logic [BYTE_W-1:0] lsr_v, msr_v, iir_v;
  logic             thre_set, thre_clr;

  uart_reg_decode u_dec (.clk(clk), .rst_n(rst_n), .addr(addr),
                         .dlab(lcr_q[DLAB_BIT]), .tgt(tgt));

  uart_irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .ien(ien_q),
    .line_cond(|err_q), .rxd_cond(rx_avail),
    .thre_cond(thre_flag & thr_empty), .mdm_cond(|delta_q),
    .gate(mcr_q[OUT2_BIT]), .id(id), .irq(irq));

  assign lsr_v = {1'b0, thr_empty, thr_empty, err_q, rx_avail};
  assign msr_v = {line_q, delta_q};
  assign iir_v = {{2{fen_q}}, 2'b00, id};

  always_comb begin
    rdata = '0;
    if (tgt.data)    rdata = rx_data;
    if (tgt.div_lo)  rdata = div_lo_q;
    if (tgt.div_hi)  rdata = div_hi_q;
    if (tgt.ien)     rdata = {{(BYTE_W-N_SRC){1'b0}}, ien_q};
    if (tgt.ident)   rdata = iir_v;
    if (tgt.lctl)    rdata = lcr_q;
    if (tgt.mctl)    rdata = {{(BYTE_W-5){1'b0}}, mcr_q};
    if (tgt.lstat)   rdata = lsr_v;
    if (tgt.mstat)   rdata = msr_v;
    if (tgt.scratch) rdata = scr_q;
  end

  assign rx_pop    = rd_en & tgt.data;
  assign tx_valid  = wr_en & tgt.data;
  assign tx_data   = wdata;
  assign fifo_wr   = wr_en & tgt.ident;
  assign fifo_ctrl = wdata;
  assign fifo_en   = fen_q;
  assign lcr       = lcr_q;
  assign mcr       = mcr_q;
  assign divisor   = {div_hi_q, div_lo_q};

  assign thre_set = (thr_empty & ~thr_q) |
                    (wr_en & tgt.ien & wdata[1] & ~ien_q[1] & thr_empty);
  assign thre_clr = (wr_en & tgt.data) | (rd_en & tgt.ident & (id == ID_THRE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0; lcr_q <= '0; mcr_q <= '0; scr_q <= '0;
      div_lo_q <= '0; div_hi_q <= '0; fen_q <= 1'b0;
      err_q <= '0; line_q <= '0; delta_q <= '0;
      thr_q <= 1'b0; thre_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        if (tgt.ien)     ien_q    <= wdata[N_SRC-1:0];
        if (tgt.lctl)    lcr_q    <= wdata;
        if (tgt.mctl)    mcr_q    <= wdata[4:0];
        if (tgt.scratch) scr_q    <= wdata;
        if (tgt.div_lo)  div_lo_q <= wdata;
        if (tgt.div_hi)  div_hi_q <= wdata;
        if (tgt.ident)   fen_q    <= wdata[0];
      end
      err_q   <= ((rd_en & tgt.lstat) ? '0 : err_q) | line_err;
      delta_q <= ((rd_en & tgt.mstat) ? '0 : delta_q) | (modem_in ^ line_q);
      line_q  <= modem_in;
      thr_q   <= thr_empty;
      if (thre_clr)      thre_flag <= 1'b0;
      else if (thre_set) thre_flag <= 1'b1;
    end
  end

  a_r3_divisor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(divisor));
  a_r10_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tgt.data) |=> !thre_flag);
  a_r7_errors_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_en && tgt.lstat)) |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: tb/test_uart_regfile.sv
module test_uart_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata, rx_data = 8'h00, tx_data, lcr, fifo_ctrl;
  logic       rx_avail = 1'b0, rx_pop, tx_valid, thr_empty = 1'b0;
  logic [3:0] line_err = '0, modem_in = '0;
  logic [4:0] mcr;
  logic       fifo_wr, fifo_en, irq;
  logic [15:0] divisor;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_regfile i_uart_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .rx_data(rx_data), .rx_avail(rx_avail),
    .rx_pop(rx_pop), .tx_data(tx_data), .tx_valid(tx_valid),
    .thr_empty(thr_empty), .line_err(line_err), .modem_in(modem_in),
    .lcr(lcr), .mcr(mcr), .fifo_ctrl(fifo_ctrl), .fifo_wr(fifo_wr),
    .fifo_en(fifo_en), .divisor(divisor), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write; returns the pulse outputs seen during the strobe
  task automatic wr(input logic [2:0] a, input logic [7:0] d,
                    output logic txv, output logic fw);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    #1 txv = tx_valid; fw = fifo_wr;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr0(input logic [2:0] a, input logic [7:0] d);
    logic t, f;
    wr(a, d, t, f);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata; pop = rx_pop;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d; logic p;
    rd(a, d, p);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R1 lcr", lcr, 8'h00);
    check("R1 mcr", mcr, 5'h00);
    check("R1 divisor", divisor, 16'h0000);
    check("R1 irq", irq, 1'b0);
    rd_chk("R1 ier", 3'd1, 8'h00);
    rd_chk("R1 scratch", 3'd7, 8'h00);
    rd_chk("R1 ident", 3'd2, 8'h01);
  endtask

  task automatic t_data_path;
    logic [7:0] d; logic p, t, f;
    rx_data = 8'hA7;
    rd(3'd0, d, p);
    check("R2 rx byte", d, 8'hA7);
    check("R2 rx_pop", p, 1'b1);
    @(negedge clk); addr = 3'd0; wdata = 8'h3C; wr_en = 1'b1;
    #1 check("R2 tx_valid", tx_valid, 1'b1);
    check("R2 tx_data", tx_data, 8'h3C);
    @(negedge clk); wr_en = 1'b0;
    #1 check("R2 tx_valid one cycle", tx_valid, 1'b0);
    wr(3'd2, 8'hC1, t, f);
    check("R5 fifo_wr", f, 1'b1);
    check("R5 fifo_en", fifo_en, 1'b1);
    rd_chk("R5 ident fifo bits", 3'd2, 8'hC1);
    wr0(3'd2, 8'h00);
  endtask

  task automatic t_divisor;
    logic [7:0] d; logic p, t, f;
    wr0(3'd3, 8'h83);
    check("R6 lcr out", lcr, 8'h83);
    wr(3'd0, 8'h34, t, f);
    check("R3 no tx_valid", t, 1'b0);
    wr0(3'd1, 8'h12);
    check("R3 divisor", divisor, 16'h1234);
    rd(3'd0, d, p);
    check("R3 div lo", d, 8'h34);
    check("R3 no rx_pop", p, 1'b0);
    rd_chk("R3 div hi", 3'd1, 8'h12);
    wr0(3'd7, 8'h5A);
    rd_chk("R6 scratch dlab1", 3'd7, 8'h5A);
    wr(3'd2, 8'h00, t, f);
    check("R5 fifo_wr dlab1", f, 1'b1);
    wr0(3'd3, 8'h03);
    rd_chk("R3 ier untouched", 3'd1, 8'h00);
    check("R3 divisor kept", divisor, 16'h1234);
    wr0(3'd1, 8'hFF);
    rd_chk("R4 ier bits", 3'd1, 8'h0F);
    wr0(3'd1, 8'h00);
    wr0(3'd4, 8'hFF);
    rd_chk("R6 mcr bits", 3'd4, 8'h1F);
    wr0(3'd4, 8'h00);
    rd_chk("R6 lcr read", 3'd3, 8'h03);
  endtask

  task automatic t_status;
    rx_avail = 1'b1; thr_empty = 1'b1;
    @(negedge clk); line_err = 4'b0101;
    @(negedge clk); line_err = 4'b0000;
    wr0(3'd5, 8'h00);
    rd_chk("R7 lsr errors", 3'd5, 8'h6B);
    rd_chk("R7 lsr cleared", 3'd5, 8'h61);
    @(negedge clk); modem_in = 4'b1001;
    @(negedge clk);
    wr0(3'd6, 8'h00);
    rd_chk("R8 msr delta", 3'd6, 8'h99);
    rd_chk("R8 msr cleared", 3'd6, 8'h90);
    rx_avail = 1'b0;
  endtask

  task automatic t_irq;
    // thr_empty already high and flag set from its earlier rise
    thr_empty = 1'b0;
    wr0(3'd4, 8'h08);
    wr0(3'd1, 8'h0F);
    rd_chk("R9 idle", 3'd2, 8'h01);
    check("R11 idle irq", irq, 1'b0);
    @(negedge clk); thr_empty = 1'b1;
    @(negedge clk);
    check("R11 thre irq", irq, 1'b1);
    rd_chk("R10 thre code", 3'd2, 8'h02);
    rd_chk("R10 thre cleared by ident read", 3'd2, 8'h01);
    wr0(3'd1, 8'h0D);
    wr0(3'd1, 8'h0F);
    rd_chk("R10 enable sets", 3'd2, 8'h02);
    wr0(3'd0, 8'h55);
    rd_chk("R10 thr write clears", 3'd2, 8'h01);
    @(negedge clk); modem_in = 4'b1000;
    @(negedge clk);
    rd_chk("R9 modem code", 3'd2, 8'h00);
    rx_avail = 1'b1;
    rd_chk("R9 rxd over modem", 3'd2, 8'h04);
    @(negedge clk); line_err = 4'b0010;
    @(negedge clk); line_err = 4'b0000;
    rd_chk("R9 line first", 3'd2, 8'h06);
    rd_chk("R9 lsr read", 3'd5, 8'h65);
    rd_chk("R9 back to rxd", 3'd2, 8'h04);
    wr0(3'd4, 8'h00);
    check("R11 gated", irq, 1'b0);
    rd_chk("R11 code while gated", 3'd2, 8'h04);
    wr0(3'd4, 8'h08);
    check("R11 ungated", irq, 1'b1);
    rx_avail = 1'b0;
    rd_chk("R8 clear modem", 3'd6, 8'h81);
    #1 check("R11 irq drops", irq, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_data_path;
    t_divisor;
    t_status;
    t_irq;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule